// File: doc/BRIEF.md
# I/O Address Translation Walker

This block turns a device-side I/O virtual address (IOVA) into a physical address for one stream. The walk has three stages. A per-stream root register is picked from a bank of four. That register points at a first-level table in memory. The first-level entry points at a second-level table, and the second-level entry gives the output page frame. Pages are 16 KiB, so the low 14 IOVA bits pass straight through as the page offset.

A client presents a stream number and a 40-bit IOVA while `ready` is high. The walker then fetches the table entries it needs through a simple read port, one read at a time. It finishes with a one-cycle response that carries either a physical address or a one-hot fault code. The response also echoes the stream and the IOVA, so a fault can be logged against the request that caused it.

Top module: `io_table_walker`

## Requirements
- R1: `ready` is high only while the walker is idle. A request presented while the walker is busy is ignored: it changes neither the response nor the memory reads of the walk in progress. After `respValid`, `ready` returns high on the next cycle.
- R2: IOVA bits 39:36 pick the root register. When they hold a value of 4 or more, the response has `respCode` = 4'b1000 and no memory read is made.
- R3: Root register bit 31 is its valid flag. When it is 0, the response has `respCode` = 4'b0001 and no memory read is made. The register for stream s and root r sits at bits [(s*4+r)*32 +: 32] of `rootRegs`.
- R4: The first read address is (root bits 30:0 shifted left by 12) + IOVA[35:25]*8.
- R5: A first-level entry whose bit 0 is 0 ends the walk after exactly one read, with `respCode` = 4'b0010.
- R6: The second read address is (first-level entry bits 39:14 shifted left by 14) + IOVA[24:14]*8. Entry bits 63:40 and bit 1 do not affect it.
- R7: A second-level entry whose bit 0 is 0 ends the walk after exactly two reads, with `respCode` = 4'b0100.
- R8: A valid second-level entry gives `respCode` = 0 and `respPa` = {entry bits 39:14, IOVA[13:0]}.
- R9: `respValid` is a single-cycle pulse. While it is high, `respStream` and `respIova` equal the accepted request's stream and IOVA.
- R10: At most one read is outstanding. `memReqValid` is not raised again until `memRspValid` has returned the previous read.
- R11: After reset, `ready` = 1, `respValid` = 0 and `memReqValid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqStream | input | 4 | Stream number of the request |
| reqIova | input | 40 | I/O virtual address to translate |
| ready | output | 1 | Walker idle, request accepted |
| rootRegs | input | 2048 | Root registers, 4 per stream, 32 bits each |
| memReqValid | output | 1 | Table read request (one-cycle pulse) |
| memReqAddr | output | 43 | Byte address of the 64-bit entry |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Entry read, little-endian 64-bit word |
| respValid | output | 1 | Result pulse |
| respCode | output | 4 | One-hot fault code, 0 on success |
| respPa | output | 40 | Translated physical address |
| respStream | output | 4 | Stream of the finished request |
| respIova | output | 40 | IOVA of the finished request |

## Verification
The assertions assume a well-behaved memory. It returns exactly one `memRspValid` per `memReqValid` and never raises `memRspValid` when no read is pending. The bench's memory model follows this by holding a single pending slot and answering it after zero to three idle cycles. The entries it returns are computed from the address, with junk in the subpage and upper bits. The sweep covers every stream against every root index, including out-of-range ones, under a mix of valid and invalid entries. Busy-time requests are injected only while `ready` is low.

// File: rtl/iow_pkg.sv
package iow_pkg;
  localparam int PAGE_BITS = 14;
  localparam int IDX_BITS  = 11;
  localparam int L1_LO     = PAGE_BITS + IDX_BITS;
  localparam int ROOT_LO   = L1_LO + IDX_BITS;
  localparam int FRAME_HI  = 39;
  localparam int BASE_W    = 32;
  localparam int BASE_SHIFT = 12;

  localparam logic [3:0] FAULT_ROOT  = 4'b0001;
  localparam logic [3:0] FAULT_MID   = 4'b0010;
  localparam logic [3:0] FAULT_LEAF  = 4'b0100;
  localparam logic [3:0] FAULT_RANGE = 4'b1000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROOT, ST_RD1, ST_WT1, ST_RD2, ST_WT2, ST_DONE
  } walk_state_t;

  typedef struct packed {
    logic       captureReq;
    logic       loadRoot;
    logic       loadTable;
    logic       loadLeaf;
    logic       useL2Idx;
    logic [3:0] faultSet;
  } strobe_t;

  typedef struct packed {
    logic rootOutOfRange;
    logic rootValid;
    logic entryValid;
  } status_t;
endpackage

// File: rtl/iow_ctrl.sv
module iow_ctrl
  import iow_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memRspValid,
  input  status_t stat,
  output strobe_t strobe,
  output logic    ready,
  output logic    memReqValid,
  output logic    respValid
);
  walk_state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.captureReq = 1'b1;
        nextState = ST_ROOT;
      end
      ST_ROOT: begin
        if (stat.rootOutOfRange) begin
          strobe.faultSet = FAULT_RANGE;
          nextState = ST_DONE;
        end else if (!stat.rootValid) begin
          strobe.faultSet = FAULT_ROOT;
          nextState = ST_DONE;
        end else begin
          strobe.loadRoot = 1'b1;
          nextState = ST_RD1;
        end
      end
      ST_RD1: nextState = ST_WT1;
      ST_WT1: if (memRspValid) begin
        if (!stat.entryValid) begin
          strobe.faultSet = FAULT_MID;
          nextState = ST_DONE;
        end else begin
          strobe.loadTable = 1'b1;
          nextState = ST_RD2;
        end
      end
      ST_RD2: begin
        strobe.useL2Idx = 1'b1;
        nextState = ST_WT2;
      end
      ST_WT2: if (memRspValid) begin
        if (!stat.entryValid) strobe.faultSet = FAULT_LEAF;
        else                  strobe.loadLeaf = 1'b1;
        nextState = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign ready       = (state == ST_IDLE);
  assign memReqValid = (state == ST_RD1) || (state == ST_RD2);
  assign respValid   = (state == ST_DONE);
endmodule

// File: rtl/iow_datapath.sv
module iow_datapath
  import iow_pkg::*;
#(
  parameter int SID_W  = 4,
  parameter int ROOTS  = 4,
  parameter int IOVA_W = 40,
  parameter int PA_W   = 40,
  parameter int ADDR_W = BASE_W - 1 + BASE_SHIFT,
  parameter int DATA_W = 64
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  strobe_t                            strobe,
  output status_t                            stat,
  input  logic [SID_W-1:0]                   reqStream,
  input  logic [IOVA_W-1:0]                  reqIova,
  input  logic [(1<<SID_W)*ROOTS*BASE_W-1:0] rootRegs,
  output logic [ADDR_W-1:0]                  memReqAddr,
  input  logic [DATA_W-1:0]                  memRspData,
  output logic [3:0]                         respCode,
  output logic [PA_W-1:0]                    respPa,
  output logic [SID_W-1:0]                   respStream,
  output logic [IOVA_W-1:0]                  respIova
);
  localparam int STREAMS = 1 << SID_W;
  localparam int RIDX_W  = $clog2(ROOTS);
  localparam int SEL_W   = SID_W + RIDX_W;
  localparam int RSEL_W  = IOVA_W - ROOT_LO;
  localparam int FRAME_W = FRAME_HI - PAGE_BITS + 1;

  logic [SID_W-1:0]  sidQ;
  logic [IOVA_W-1:0] iovaQ;
  logic [ADDR_W-1:0] tableBaseQ;
  logic [PA_W-1:0]   paQ;
  logic [3:0]        codeQ;

  logic [BASE_W-1:0] regArr [STREAMS*ROOTS];
  for (genvar g = 0; g < STREAMS*ROOTS; g++) begin : g_regs
    assign regArr[g] = rootRegs[g*BASE_W +: BASE_W];
  end

  logic [RSEL_W-1:0]   rootSel;
  logic [SEL_W-1:0]    selIdx;
  logic [BASE_W-1:0]   selReg;
  logic [IDX_BITS-1:0] tblIdx;
  logic [FRAME_W-1:0]  rspFrame;

  assign rootSel  = iovaQ[IOVA_W-1:ROOT_LO];
  assign selIdx   = {sidQ, rootSel[RIDX_W-1:0]};
  assign selReg   = regArr[selIdx];
  assign rspFrame = memRspData[FRAME_HI:PAGE_BITS];

  assign stat.rootOutOfRange = rootSel > RSEL_W'(ROOTS - 1);
  assign stat.rootValid      = selReg[BASE_W-1];
  assign stat.entryValid     = memRspData[0];

  assign tblIdx     = strobe.useL2Idx ? iovaQ[L1_LO-1:PAGE_BITS] : iovaQ[ROOT_LO-1:L1_LO];
  assign memReqAddr = tableBaseQ + ADDR_W'({tblIdx, 3'b000});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sidQ       <= '0;
      iovaQ      <= '0;
      tableBaseQ <= '0;
      paQ        <= '0;
      codeQ      <= '0;
    end else begin
      if (strobe.captureReq) begin
        sidQ  <= reqStream;
        iovaQ <= reqIova;
        paQ   <= '0;
        codeQ <= '0;
      end
      if (strobe.loadRoot)
        tableBaseQ <= ADDR_W'({selReg[BASE_W-2:0], BASE_SHIFT'(0)});
      if (strobe.loadTable)
        tableBaseQ <= ADDR_W'({rspFrame, PAGE_BITS'(0)});
      if (strobe.loadLeaf)
        paQ <= PA_W'({rspFrame, iovaQ[PAGE_BITS-1:0]});
      if (|strobe.faultSet)
        codeQ <= strobe.faultSet;
    end
  end

  assign respCode   = codeQ;
  assign respPa     = paQ;
  assign respStream = sidQ;
  assign respIova   = iovaQ;
endmodule

// File: rtl/io_table_walker.sv
module io_table_walker
  import iow_pkg::*;
#(
  parameter int SID_W  = 4,
  parameter int ROOTS  = 4,
  parameter int IOVA_W = 40,
  parameter int PA_W   = 40,
  parameter int ADDR_W = 43,
  parameter int DATA_W = 64
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  input  logic [SID_W-1:0]                   reqStream,
  input  logic [IOVA_W-1:0]                  reqIova,
  output logic                               ready,
  input  logic [(1<<SID_W)*ROOTS*BASE_W-1:0] rootRegs,
  output logic                               memReqValid,
  output logic [ADDR_W-1:0]                  memReqAddr,
  input  logic                               memRspValid,
  input  logic [DATA_W-1:0]                  memRspData,
  output logic                               respValid,
  output logic [3:0]                         respCode,
  output logic [PA_W-1:0]                    respPa,
  output logic [SID_W-1:0]                   respStream,
  output logic [IOVA_W-1:0]                  respIova
);
  strobe_t strobe;
  status_t stat;

  iow_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .stat(stat), .strobe(strobe), .ready(ready), .memReqValid(memReqValid),
    .respValid(respValid)
  );

  iow_datapath #(
    .SID_W(SID_W), .ROOTS(ROOTS), .IOVA_W(IOVA_W), .PA_W(PA_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stat(stat),
    .reqStream(reqStream), .reqIova(reqIova), .rootRegs(rootRegs),
    .memReqAddr(memReqAddr), .memRspData(memRspData), .respCode(respCode),
    .respPa(respPa), .respStream(respStream), .respIova(respIova)
  );
endmodule

// File: rtl/iow_checker.sv
module iow_checker #(
  parameter int IOVA_W = 40,
  parameter int PA_W   = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              ready,
  input logic              memReqValid,
  input logic              memRspValid,
  input logic              respValid,
  input logic [3:0]        respCode,
  input logic [PA_W-1:0]   respPa,
  input logic [IOVA_W-1:0] respIova
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rstN)            outstanding <= 1'b0;
    else if (memReqValid) outstanding <= 1'b1;
    else if (memRspValid) outstanding <= 1'b0;
  end

  p_single_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(memReqValid && outstanding));

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ready && reqValid) |=> !ready);

  p_ready_after_resp_r1: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> ready);

  p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  p_code_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $onehot0(respCode));

  p_offset_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respCode == 4'b0000) |-> respPa[13:0] == respIova[13:0]);

  p_no_read_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !memReqValid);
endmodule

bind io_table_walker iow_checker #(.IOVA_W(IOVA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .ready(ready),
  .memReqValid(memReqValid), .memRspValid(memRspValid), .respValid(respValid),
  .respCode(respCode), .respPa(respPa), .respIova(respIova)
);

// File: tb/tb_io_table_walker.sv
module tb_io_table_walker;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [3:0]   reqStream = '0;
  logic [39:0]  reqIova = '0;
  logic         ready;
  logic [2047:0] rootRegs;
  logic         memReqValid;
  logic [42:0]  memReqAddr;
  logic         memRspValid = 1'b0;
  logic [63:0]  memRspData = '0;
  logic         respValid;
  logic [3:0]   respCode;
  logic [39:0]  respPa;
  logic [3:0]   respStream;
  logic [39:0]  respIova;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  io_table_walker dut (.*);

  always #10 clk = ~clk;

  // entry contents computed from the address; upper bits carry junk
  function automatic logic [63:0] entryAt(input logic [42:0] a);
    logic [63:0] e;
    logic [25:0] fr;
    logic        v;
    if (!a[39]) begin
      v  = ((a >> 3) % 5) != 2;
      fr = 26'h2000000 | 26'(a[20:3]);
    end else begin
      v  = ((a >> 3) % 7) != 3;
      fr = 26'((a >> 3) * 40503);
    end
    e = {24'hA5C3F0, fr, 12'b0, 1'b0, 1'b1, v};
    return e;
  endfunction

  // memory model: one pending slot, 0..3 extra wait cycles
  logic        pend = 1'b0;
  logic [42:0] pendAddr = '0;
  logic [1:0]  waitCnt = '0;
  logic [42:0] rdAddr [2];
  int          rdCount = 0;
  int          r10Fail = 0;

  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (memReqValid) begin
      if (pend) r10Fail <= r10Fail + 1;
      pend     <= 1'b1;
      pendAddr <= memReqAddr;
      waitCnt  <= memReqAddr[5:4];
      if (rdCount < 2) rdAddr[rdCount] <= memReqAddr;
      rdCount  <= rdCount + 1;
    end else if (pend) begin
      if (waitCnt == 0) begin
        memRspValid <= 1'b1;
        memRspData  <= entryAt(pendAddr);
        pend        <= 1'b0;
      end else waitCnt <= waitCnt - 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rootVal(input int s, input int r);
    logic [30:0] f;
    f = 31'(32'h100 + s * 4 + r);
    return {((s + r) % 3) != 0, f};
  endfunction

  task automatic runWalk(input int s, input logic [39:0] iova, input bit poke);
    logic [3:0]  rsel;
    logic [31:0] rreg;
    logic [42:0] a1, a2;
    logic [63:0] e1, e2;
    logic [3:0]  expCode;
    int          expReads;
    int          t;
    bit          seen;
    logic [39:0] expPa;
    expPa = '0;
    @(negedge clk);
    check(ready === 1'b1, "R1 ready idle", 64'(ready), 64'd1);
    reqValid  = 1'b1;
    reqStream = 4'(s);
    reqIova   = iova;
    rdCount   = 0;
    @(negedge clk);
    check(ready === 1'b0, "R1 busy after accept", 64'(ready), 64'd0);
    if (poke) begin
      reqStream = ~4'(s);
      reqIova   = ~iova;
    end else reqValid = 1'b0;
    // expected walk from the requirements
    rsel = iova[39:36];
    a1 = '0; a2 = '0; e1 = '0; e2 = '0;
    if (rsel >= 4) begin expCode = 4'b1000; expReads = 0; end
    else begin
      rreg = rootVal(s, int'(rsel));
      if (!rreg[31]) begin expCode = 4'b0001; expReads = 0; end
      else begin
        a1 = {rreg[30:0], 12'b0} + 43'({iova[35:25], 3'b000});
        e1 = entryAt(a1);
        if (!e1[0]) begin expCode = 4'b0010; expReads = 1; end
        else begin
          a2 = 43'({e1[39:14], 14'b0}) + 43'({iova[24:14], 3'b000});
          e2 = entryAt(a2);
          if (!e2[0]) begin expCode = 4'b0100; expReads = 2; end
          else begin expCode = 4'b0000; expReads = 2; expPa = {e2[39:14], iova[13:0]}; end
        end
      end
    end
    seen = 0;
    for (t = 0; t < 40 && !seen; t++) begin
      if (respValid) seen = 1;
      else @(negedge clk);
    end
    reqValid = 1'b0;
    check(seen, "R9 response arrives", 64'(seen), 64'd1);
    if (!seen) return;
    case (expCode)
      4'b1000: check(respCode == expCode, "R2 range fault", 64'(respCode), 64'(expCode));
      4'b0001: check(respCode == expCode, "R3 root fault", 64'(respCode), 64'(expCode));
      4'b0010: check(respCode == expCode, "R5 mid fault", 64'(respCode), 64'(expCode));
      4'b0100: check(respCode == expCode, "R7 leaf fault", 64'(respCode), 64'(expCode));
      default: begin
        check(respCode == 4'b0, "R8 success code", 64'(respCode), 64'd0);
        check(respPa == expPa, "R8 physical address", 64'(respPa), 64'(expPa));
      end
    endcase
    check(rdCount == expReads, expReads == 0 ? "R2 R3 no reads" : "R5 R7 read count",
          64'(rdCount), 64'(expReads));
    if (expReads >= 1) check(rdAddr[0] == a1, "R4 first address", 64'(rdAddr[0]), 64'(a1));
    if (expReads >= 2) check(rdAddr[1] == a2, "R6 second address", 64'(rdAddr[1]), 64'(a2));
    check(respStream == 4'(s) && respIova == iova, poke ? "R1 busy request ignored" : "R9 echo",
          64'(respIova), 64'(iova));
    @(negedge clk);
    check(respValid === 1'b0, "R9 single pulse", 64'(respValid), 64'd0);
    check(ready === 1'b1, "R1 ready after response", 64'(ready), 64'd1);
  endtask

  initial begin
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 4; r++)
        rootRegs[(s*4+r)*32 +: 32] = rootVal(s, r);
    repeat (3) @(negedge clk);
    check(ready === 1'b1 && respValid === 1'b0 && memReqValid === 1'b0, "R11 reset state",
          {61'b0, ready, respValid, memReqValid}, 64'b100);
    rstN = 1'b1;
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 6; r++)
        for (int k = 0; k < 8; k++) begin
          logic [3:0]  rs;
          logic [10:0] i1, i2;
          logic [13:0] off;
          rs  = (r == 5) ? 4'hF : 4'(r);
          i1  = (k == 0) ? 11'd0 : (k == 1) ? 11'h7FF : 11'((k * 397 + s) % 2048);
          i2  = (k == 0) ? 11'h7FF : (k == 1) ? 11'd0 : 11'((k * 1223 + 5 + r) % 2048);
          off = 14'((k * 4099 + s * 17) & 14'h3FFF);
          runWalk(s, {rs, i1, i2, off}, (k == 3));
        end
    check(r10Fail == 0, "R10 one outstanding read", 64'(r10Fail), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule